// File: doc/BRIEF.md
# Program-Only Nybble Store with Single-Error Correction

The block holds a small array of 4-bit values. Each value is kept as a 7-bit codeword made of the four data bits and three guard bits. The cells act like non-volatile storage. An erase returns one word to the blank state, where every bit is 0. A program can only set bits from 0 to 1, so it ORs the new pattern into whatever the word already holds instead of replacing it. A read recomputes the guard bits from the stored data bits and forms a 3-bit syndrome. It repairs any single flipped bit and reports whether a repair was made.

Because a program merges with the old contents, overwriting a word that is not blank can leave a pattern that is not a valid codeword. A later read would then "correct" that pattern to a value nobody wrote. The block therefore raises a warning on every program whose merged result differs from the pattern that was asked for.

A second program flavour ORs an arbitrary 7-bit pattern straight into a word, bypassing the encoder. This lets guard bits and single-bit faults be written on purpose.

Top module: `prog_only_ecc_store`

## Requirements
- R1: A codeword is laid out as bits [3:0] = data d3..d0, bit 4 = guard A = d0^d1^d3, bit 5 = guard B = d0^d2^d3, bit 6 = guard C = d1^d2^d3. The blank word 0000000 is a valid codeword.
- R2: An erase (op code 2) sets the addressed word to all zeros. A read of that word then returns data 0000 with the repair flag low.
- R3: A program (op code 1) ORs the codeword of the requested data into the addressed word. No bit ever goes from 1 to 0 except by erase.
- R4: A read (op code 0) yields `rd_valid` high for exactly the one cycle after the request, together with `rd_data` and `rd_fixed`.
- R5: On read, the syndrome is the stored guard bits XOR the guard bits recomputed from the stored data. The syndrome patterns map to a flipped data bit as follows: A and B flip d0; A and C flip d1; B and C flip d2; all three flip d3. That data bit is inverted on output and `rd_fixed` is 1.
- R6: A syndrome with exactly one guard bit set passes the data through unchanged, with `rd_fixed` equal to 1.
- R7: A word whose syndrome is zero is returned unchanged, with `rd_fixed` equal to 0.
- R8: In the cycle after a program (op 1 or 3), `wr_warn` is 1 exactly when the merged word differs from the requested pattern. It is 0 after any other operation.
- R9: A raw program (op code 3) ORs `req_raw` into the addressed word.
- R10: After reset every word is blank and all outputs are 0.
- R11: With `req_valid` low, storage does not change, and `rd_valid`, `rd_data`, `rd_fixed` and `wr_warn` are all 0 in the next cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request strobe |
| req_op | input | 2 | 0 read, 1 program data, 2 erase, 3 raw program |
| req_addr | input | log2(DEPTH) | Word address |
| req_data | input | 4 | Data to encode for op 1 |
| req_raw | input | 7 | Pattern ORed in by op 3 |
| rd_valid | output | 1 | Read result valid |
| rd_data | output | 4 | Corrected read data |
| rd_fixed | output | 1 | Nonzero syndrome seen on this read |
| wr_warn | output | 1 | Merged word differs from the requested pattern |

## Verification
The bench builds the block with the default DEPTH of 16, which gives every one of the sixteen nybble values its own address. At that size, all 112 single-bit faults can be placed by erase plus raw program, and each one is read back through the syndrome map. A random phase then confines addresses to the lowest four words. That keeps collisions frequent, so program merges, multi-bit patterns that get miscorrected, and warnings all occur often enough to compare against the reference.

// File: rtl/pecc_pkg.sv
`timescale 1ns/1ps
package pecc_pkg;
   localparam int DW = 4;
   localparam int GW = 3;
   localparam int CW = DW + GW;

   typedef enum logic [1:0] {
      OP_READ  = 2'd0,
      OP_PROG  = 2'd1,
      OP_ERASE = 2'd2,
      OP_RAW   = 2'd3
   } pecc_op_e;

   // syndrome {C,B,A} that blames data bit i, packed 3 bits per data bit
   localparam logic [DW*GW-1:0] BLAME_SYND = {3'b111, 3'b110, 3'b101, 3'b011};

   // guard equation taps: bit j of GUARD_TAPS[g*DW +: DW] selects data bit j
   localparam logic [GW*DW-1:0] GUARD_TAPS = {4'b1110, 4'b1101, 4'b1011};
endpackage

// File: rtl/pecc_encode.sv
`timescale 1ns/1ps
module pecc_encode
   import pecc_pkg::*;
(
   input  logic [DW-1:0] enc_data,
   output logic [CW-1:0] enc_word
);
   logic [GW-1:0] guard;

   for (genvar g = 0; g < GW; g++) begin : g_guard
      assign guard[g] = ^(enc_data & GUARD_TAPS[g*DW +: DW]);
   end

   assign enc_word = {guard, enc_data};
endmodule

// File: rtl/pecc_decode.sv
`timescale 1ns/1ps
module pecc_decode
   import pecc_pkg::*;
(
   input  logic [CW-1:0] dec_word,
   output logic [DW-1:0] dec_data,
   output logic          dec_fixed
);
   logic [CW-1:0] recoded;
   logic [GW-1:0] synd;

   pecc_encode u_reenc (
      .enc_data (dec_word[DW-1:0]),
      .enc_word (recoded)
   );

   assign synd = dec_word[CW-1:DW] ^ recoded[CW-1:DW];

   for (genvar i = 0; i < DW; i++) begin : g_fix
      assign dec_data[i] = dec_word[i] ^ (synd == BLAME_SYND[i*GW +: GW]);
   end

   assign dec_fixed = |synd;
endmodule

// File: rtl/pecc_cells.sv
`timescale 1ns/1ps
module pecc_cells
   import pecc_pkg::*;
#(
   parameter  int DEPTH = 16,
   localparam int AW    = $clog2(DEPTH)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          set_en,
   input  logic          clr_en,
   input  logic [AW-1:0] addr,
   input  logic [CW-1:0] set_pat,
   output logic [CW-1:0] rd_word
);
   logic [CW-1:0] cell_view [DEPTH];

   for (genvar w = 0; w < DEPTH; w++) begin : g_word
      logic [CW-1:0] q;
      logic          hit;
      assign hit = (addr == AW'(w));
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            q <= '0;
         else if (hit && clr_en)
            q <= '0;
         else if (hit && set_en)
            q <= q | set_pat;
      end
      assign cell_view[w] = q;
   end

   assign rd_word = cell_view[addr];
endmodule

// File: rtl/prog_only_ecc_store.sv
`timescale 1ns/1ps
module prog_only_ecc_store
   import pecc_pkg::*;
#(
   parameter  int DEPTH = 16,
   localparam int AW    = $clog2(DEPTH)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          req_valid,
   input  logic [1:0]    req_op,
   input  logic [AW-1:0] req_addr,
   input  logic [3:0]    req_data,
   input  logic [6:0]    req_raw,
   output logic          rd_valid,
   output logic [3:0]    rd_data,
   output logic          rd_fixed,
   output logic          wr_warn
);
   if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
      $error("DEPTH must be a power of two and at least 2");
   end
   if (DW != 4 || GW != 3) begin : g_bad_code
      $error("guard equations are defined for 4 data and 3 guard bits");
   end

   logic          is_read, is_prog, is_raw, is_erase;
   logic [CW-1:0] enc_word, target, cur_word, merged;
   logic [DW-1:0] fix_data;
   logic          fix_flag;

   assign is_read  = req_valid && (req_op == OP_READ);
   assign is_prog  = req_valid && (req_op == OP_PROG);
   assign is_raw   = req_valid && (req_op == OP_RAW);
   assign is_erase = req_valid && (req_op == OP_ERASE);

   pecc_encode u_enc (
      .enc_data (req_data),
      .enc_word (enc_word)
   );

   assign target = is_raw ? req_raw : enc_word;

   pecc_cells #(.DEPTH(DEPTH)) u_cells (
      .clk     (clk),
      .rst_n   (rst_n),
      .set_en  (is_prog || is_raw),
      .clr_en  (is_erase),
      .addr    (req_addr),
      .set_pat (target),
      .rd_word (cur_word)
   );

   assign merged = cur_word | target;

   pecc_decode u_dec (
      .dec_word  (cur_word),
      .dec_data  (fix_data),
      .dec_fixed (fix_flag)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_valid <= 1'b0;
         rd_data  <= '0;
         rd_fixed <= 1'b0;
         wr_warn  <= 1'b0;
      end else begin
         rd_valid <= is_read;
         rd_data  <= is_read ? fix_data : '0;
         rd_fixed <= is_read && fix_flag;
         wr_warn  <= (is_prog || is_raw) && (merged != target);
      end
   end
endmodule

// File: rtl/pecc_checker.sv
`timescale 1ns/1ps
module pecc_checker #(
   parameter int AW = 4
) (
   input logic          clk,
   input logic          rst_n,
   input logic          req_valid,
   input logic [1:0]    req_op,
   input logic [AW-1:0] req_addr,
   input logic          rd_valid,
   input logic [3:0]    rd_data,
   input logic          rd_fixed,
   input logic          wr_warn
);
   p_read_answers_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_op == 2'd0) |=> rd_valid);

   p_no_spurious_read_r4: assert property (@(posedge clk) disable iff (!rst_n)
      rd_valid |-> $past(req_valid && req_op == 2'd0));

   p_warn_after_prog_r8: assert property (@(posedge clk) disable iff (!rst_n)
      wr_warn |-> $past(req_valid && (req_op == 2'd1 || req_op == 2'd3)));

   p_idle_outputs_r11: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_valid |-> (rd_data == 4'd0 && !rd_fixed));

   p_erase_then_read_blank_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_valid && $past(req_valid, 2) && $past(req_op, 2) == 2'd2
       && $past(req_addr, 2) == $past(req_addr))
      |-> (rd_data == 4'd0 && !rd_fixed));
endmodule

bind prog_only_ecc_store pecc_checker #(.AW(AW)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .req_valid (req_valid),
   .req_op    (req_op),
   .req_addr  (req_addr),
   .rd_valid  (rd_valid),
   .rd_data   (rd_data),
   .rd_fixed  (rd_fixed),
   .wr_warn   (wr_warn)
);

// File: tb/sim_prog_only_ecc_store.sv
`timescale 1ns/1ps
module sim_prog_only_ecc_store;
   localparam int DEPTH = 16;
   localparam int AW    = 4;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          req_valid = 1'b0;
   logic [1:0]    req_op = 2'd0;
   logic [AW-1:0] req_addr = '0;
   logic [3:0]    req_data = '0;
   logic [6:0]    req_raw = '0;
   logic          rd_valid, rd_fixed, wr_warn;
   logic [3:0]    rd_data;

   int n_cmp = 0;
   int n_bad = 0;
   bit finished = 0;

   logic [6:0] model [DEPTH];
   logic       e_valid, e_fixed, e_warn;
   logic [3:0] e_data;

   always #10 clk = ~clk;

   prog_only_ecc_store #(.DEPTH(DEPTH)) u0 (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
      .req_addr(req_addr), .req_data(req_data), .req_raw(req_raw),
      .rd_valid(rd_valid), .rd_data(rd_data), .rd_fixed(rd_fixed), .wr_warn(wr_warn)
   );

   function automatic logic [6:0] f_enc(input logic [3:0] d);
      logic a, b, c;
      a = d[0] ^ d[1] ^ d[3];
      b = d[0] ^ d[2] ^ d[3];
      c = d[1] ^ d[2] ^ d[3];
      return {c, b, a, d};
   endfunction

   // R5 R6 R7 reference: mismatch set between stored and recomputed guards
   task automatic f_dec(input logic [6:0] w, output logic [3:0] d, output logic fx);
      logic [6:0] re;
      logic [2:0] mis;
      re  = f_enc(w[3:0]);
      mis = w[6:4] ^ re[6:4];
      d   = w[3:0];
      case (mis)
         3'b011: d[0] = ~d[0];
         3'b101: d[1] = ~d[1];
         3'b110: d[2] = ~d[2];
         3'b111: d[3] = ~d[3];
         default: ;
      endcase
      fx = (mis != 3'b000);
   endtask

   task automatic compare(input string tag);
      n_cmp++;
      if (rd_valid !== e_valid || rd_data !== e_data || rd_fixed !== e_fixed || wr_warn !== e_warn) begin
         n_bad++;
         $display("FAIL %s: actual v=%b d=%h fx=%b w=%b expected v=%b d=%h fx=%b w=%b",
                  tag, rd_valid, rd_data, rd_fixed, wr_warn, e_valid, e_data, e_fixed, e_warn);
      end
   endtask

   // called at a negedge: drive, model the edge, compare at the next negedge
   task automatic step(input logic v, input logic [1:0] op, input logic [AW-1:0] a,
                       input logic [3:0] d, input logic [6:0] raw, input string tag);
      logic [6:0] tgt, mg;
      req_valid = v; req_op = op; req_addr = a; req_data = d; req_raw = raw;
      @(posedge clk);
      e_valid = 0; e_data = 0; e_fixed = 0; e_warn = 0;
      if (v) begin
         case (op)
            2'd0: begin e_valid = 1; f_dec(model[a], e_data, e_fixed); end
            2'd1, 2'd3: begin
               tgt = (op == 2'd1) ? f_enc(d) : raw;
               mg = model[a] | tgt;
               e_warn = (mg != tgt);
               model[a] = mg;
            end
            default: model[a] = 7'd0;
         endcase
      end
      @(negedge clk);
      compare(tag);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         n_bad++;
         $display("FAIL R4 watchdog: actual cycles=100000 expected completion earlier");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin
      for (int i = 0; i < DEPTH; i++) model[i] = 7'd0;
      e_valid = 0; e_data = 0; e_fixed = 0; e_warn = 0;
      repeat (3) @(negedge clk);
      compare("R10 outputs in reset");
      rst_n = 1'b1;
      @(negedge clk);
      compare("R10 outputs after reset");
      for (int i = 0; i < DEPTH; i++) step(1, 2'd0, AW'(i), 4'h0, 7'h0, "R10 blank after reset");

      // R1: stored word equals the guard-equation codeword
      for (int v = 0; v < 16; v++) begin
         step(1, 2'd2, AW'(v), 4'h0, 7'h0, "R2 erase");
         step(1, 2'd0, AW'(v), 4'h0, 7'h0, "R2 read blank");
         step(1, 2'd1, AW'(v), 4'(v), 7'h0, "R3 program onto blank");
         step(1, 2'd3, AW'(v), 4'h0, f_enc(4'(v)), "R1 equation codeword merges silently");
         step(1, 2'd0, AW'(v), 4'h0, 7'h0, "R7 clean read");
      end

      // R5 R6 R9: every single-bit fault of every codeword
      for (int v = 0; v < 16; v++) begin
         for (int k = 0; k < 7; k++) begin
            step(1, 2'd2, AW'(v), 4'h0, 7'h0, "R2 erase before fault");
            step(1, 2'd3, AW'(v), 4'h0, f_enc(4'(v)) ^ (7'd1 << k), "R9 raw fault pattern");
            step(1, 2'd0, AW'(v), 4'h0, 7'h0, (k < 4) ? "R5 data bit repaired" : "R6 guard bit fault");
         end
      end

      // R8 overwrite cases
      step(1, 2'd2, 4'd5, 4'h0, 7'h0, "R2 erase");
      step(1, 2'd1, 4'd5, 4'he, 7'h0, "R8 first program no warning");
      step(1, 2'd1, 4'd5, 4'h8, 7'h0, "R8 conflicting overwrite warns");
      step(1, 2'd0, 4'd5, 4'h0, 7'h0, "R5 merged word miscorrected");
      step(1, 2'd1, 4'd5, 4'hf, 7'h0, "R8 all-programmed needs no warning");
      step(1, 2'd0, 4'd5, 4'h0, 7'h0, "R3 all ones reads clean");
      step(1, 2'd1, 4'd5, 4'h0, 7'h0, "R8 zero onto full warns");
      step(1, 2'd2, 4'd6, 4'h0, 7'h0, "R2 erase");
      step(1, 2'd1, 4'd6, 4'h3, 7'h0, "R8 program");
      step(1, 2'd1, 4'd6, 4'h3, 7'h0, "R8 same value twice no warning");

      // R11: requests without valid change nothing
      step(0, 2'd2, 4'd6, 4'h0, 7'h0, "R11 ignored erase");
      step(0, 2'd0, 4'd6, 4'h0, 7'h0, "R11 ignored read");
      step(0, 2'd1, 4'd6, 4'hc, 7'h0, "R11 ignored program");
      step(1, 2'd0, 4'd6, 4'h0, 7'h0, "R11 word unchanged");

      // mixed traffic on four words
      for (int n = 0; n < 1500; n++) begin
         logic [31:0] r;
         r = $urandom;
         step(r[3:0] != 4'd0, r[5:4], AW'(r[7:6]), r[11:8], r[18:12], "R3 R8 random traffic");
      end

      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule